// File: doc/BRIEF.md
# DDR Command Timing Guard

This block sits between the command scheduler of a DDR memory controller and the PHY. It keeps a set of down-counters for every bank and for the rank as a whole. For the bank and auto-precharge flag the scheduler is presenting, it drives one "may issue now" flag per command type: ACTIVE, READ, WRITE, PRECHARGE, AUTO REFRESH and LOAD MODE. The scheduler looks at these flags before it raises its command strobe. Every spacing rule is an elaboration-time parameter counted in clock cycles. The defaults fit a 5 ns clock.

The guard covers the rules that interact with each other:

- row-to-column delay;
- minimum row-open time, and a warning before the maximum row-open time runs out;
- row cycle time;
- precharge recovery;
- activate spacing between banks;
- write recovery;
- the rank-wide gap from a write to a read;
- the condition for auto-precharge, namely that its internal precharge must not come before the minimum row-open time;
- the lockouts after a refresh and after a mode-register load.

The guard only tracks commands that it accepted. A command that arrives while its flag is low sets a sticky violation flag and is otherwise ignored.

Top module: `ddr_cmd_guard`

## Requirements
- R1: Command codes on `cmd_code` are 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH, 6 LOAD MODE and 7 reserved. The permit vector {ok_lmr,ok_ref,ok_pre,ok_wr,ok_rd,ok_act} is 6'b111001 after reset. `violation` and `row_expire` are zero after reset.
- R2: READ and WRITE are permitted only to an open bank. They are first permitted T_RCD (3) edges after the edge that accepted that bank's ACTIVE.
- R3: ACTIVE to a bank is first permitted T_RP (3) edges after an accepted PRECHARGE of that bank.
- R4: PRECHARGE of an open bank is first permitted T_RAS (8) edges after its ACTIVE. A second ACTIVE to the same bank is first permitted T_RC (11) edges after the first.
- R5: After any accepted ACTIVE, ACTIVE to any bank is blocked until T_RRD (2) edges later.
- R6: After a WRITE, PRECHARGE of that bank is first permitted T_WL+T_BURST+T_WR (6) edges later. READ to any bank is first permitted T_WL+T_BURST+T_WTR (4) edges later.
- R7: With `cmd_ap` high, READ needs at most T_BURST cycles left of the minimum row-open time, and WRITE needs at most T_WL+T_BURST+T_WR. After an auto-precharge READ or WRITE the bank counts as closed. Its next ACTIVE is first permitted (T_BURST or T_WL+T_BURST+T_WR) + T_RP edges later.
- R8: REFRESH and LOAD MODE are permitted only when every bank could accept ACTIVE. After REFRESH every permit is low for T_RFC (14) edges. After LOAD MODE every permit is low for T_MRD (2) edges.
- R9: `row_expire[b]` is high for exactly one cycle: the cycle that starts T_RAS_MAX-2 edges after the edge that accepted bank b's ACTIVE, provided the row is still open then.
- R10: A strobe with a command code 1 to 6 whose permit is low sets `violation`. It stays set until reset. Codes 0 and 7 never set it.
- R11: A refused command changes no timing or bank state.
- R12: PRECHARGE of a closed bank is permitted and starts no precharge delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code (R1) |
| cmd_bank | input | BA_W (2) | Target bank |
| cmd_ap | input | 1 | Auto-precharge request for READ/WRITE |
| ok_act | output | 1 | ACTIVE permitted for cmd_bank |
| ok_rd | output | 1 | READ permitted for cmd_bank/cmd_ap |
| ok_wr | output | 1 | WRITE permitted for cmd_bank/cmd_ap |
| ok_pre | output | 1 | PRECHARGE permitted for cmd_bank |
| ok_ref | output | 1 | REFRESH permitted |
| ok_lmr | output | 1 | LOAD MODE permitted |
| row_expire | output | NBANK (4) | Per-bank row-open timeout pulse |
| violation | output | 1 | Sticky flag for a command issued while blocked |

## Verification
The bench targets the off-by-one boundaries of each window: it probes the cycle just before a permit rises and the cycle at which it rises. A counter loaded with N instead of N-1 would show up there as a permit one cycle late. The bench also tests auto-precharge at the exact age that allows it, and checks that the implied bank closure holds back the next ACTIVE by burst plus precharge time; a guard that closed the bank at once would let that ACTIVE through early. It checks that a refused ACTIVE leaves the bank closed, where a guard that applied refused commands would start opening the row. It checks that the timeout pulse lands on its single cycle about fourteen thousand cycles after activation; an off-by-one age count would move the pulse or stretch it.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_LMR = 3'd6,
        CMD_RSV = 3'd7
    } cmd_e;

    // Accepted command aimed at one bank
    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
        logic ap;
    } bank_req_t;

    // Readiness seen from one bank
    typedef struct packed {
        logic act_ok;
        logic col_ok;
        logic pre_ok;
        logic rd_ap_ok;
        logic wr_ap_ok;
        logic expire;
    } bank_stat_t;

    typedef struct packed {
        logic lmr;
        logic rfsh;
        logic pre;
        logic wr;
        logic rd;
        logic act;
    } permit_t;

    function automatic int cnt_bits(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_guard_dcnt.sv
module ddr_guard_dcnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/ddr_guard_bank.sv
module ddr_guard_bank
    import ddr_guard_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 8,
    parameter int T_RC      = 11,
    parameter int T_RP      = 3,
    parameter int T_RAS_MAX = 14000,
    parameter int RD_AP_DLY = 2,
    parameter int WR_AP_DLY = 6,
    parameter int WR_REC    = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  bank_req_t  req,
    output bank_stat_t stat
);

    localparam int LD_MAX = max2(max2(max2(T_RCD, T_RAS), max2(T_RC, WR_REC)),
                                 max2(RD_AP_DLY, WR_AP_DLY) + T_RP);
    localparam int CW = cnt_bits(LD_MAX);
    localparam int AW = cnt_bits(T_RAS_MAX);

    logic          row_open;
    logic [AW-1:0] age;
    logic [CW-1:0] rcd_cnt, ras_cnt, rc_cnt, rp_cnt, wr_cnt;
    logic          rp_ld;
    logic [CW-1:0] rp_val;
    logic          auto_close;

    assign auto_close = (req.rd || req.wr) && req.ap;

    always_comb begin
        rp_ld  = (req.pre && row_open) || auto_close;
        if (req.rd) begin
            rp_val = CW'(RD_AP_DLY + T_RP - 1);
        end else if (req.wr) begin
            rp_val = CW'(WR_AP_DLY + T_RP - 1);
        end else begin
            rp_val = CW'(T_RP - 1);
        end
    end

    ddr_guard_dcnt #(.W(CW)) u_rcd (.clk(clk), .rst(rst), .ld(req.act),
                                    .ld_val(CW'(T_RCD - 1)), .cnt(rcd_cnt));
    ddr_guard_dcnt #(.W(CW)) u_ras (.clk(clk), .rst(rst), .ld(req.act),
                                    .ld_val(CW'(T_RAS - 1)), .cnt(ras_cnt));
    ddr_guard_dcnt #(.W(CW)) u_rc  (.clk(clk), .rst(rst), .ld(req.act),
                                    .ld_val(CW'(T_RC - 1)), .cnt(rc_cnt));
    ddr_guard_dcnt #(.W(CW)) u_rp  (.clk(clk), .rst(rst), .ld(rp_ld),
                                    .ld_val(rp_val), .cnt(rp_cnt));
    ddr_guard_dcnt #(.W(CW)) u_wr  (.clk(clk), .rst(rst), .ld(req.wr),
                                    .ld_val(CW'(WR_REC - 1)), .cnt(wr_cnt));

    always_ff @(posedge clk) begin
        if (rst) begin
            row_open <= 1'b0;
        end else if (req.act) begin
            row_open <= 1'b1;
        end else if (req.pre || auto_close) begin
            row_open <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
        end else if (req.act) begin
            age <= AW'(1);
        end else if (row_open && age != AW'(T_RAS_MAX)) begin
            age <= age + 1'b1;
        end
    end

    always_comb begin
        stat.act_ok   = !row_open && rp_cnt == '0 && rc_cnt == '0;
        stat.col_ok   = row_open && rcd_cnt == '0;
        stat.pre_ok   = !row_open || (ras_cnt == '0 && wr_cnt == '0);
        stat.rd_ap_ok = ras_cnt <= CW'(RD_AP_DLY) && wr_cnt <= CW'(RD_AP_DLY);
        stat.wr_ap_ok = ras_cnt <= CW'(WR_AP_DLY);
        stat.expire   = row_open && age == AW'(T_RAS_MAX - 1);
    end

endmodule

// File: rtl/ddr_guard_rank.sv
module ddr_guard_rank
    import ddr_guard_pkg::*;
#(
    parameter int T_RRD   = 2,
    parameter int WTR_GAP = 4,
    parameter int T_RFC   = 14,
    parameter int T_MRD   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic acc_act,
    input  logic acc_wr,
    input  logic acc_ref,
    input  logic acc_lmr,
    output logic rrd_ok,
    output logic wtr_ok,
    output logic lock_ok
);

    localparam int RW = cnt_bits(max2(max2(T_RRD, WTR_GAP), max2(T_RFC, T_MRD)));

    logic [RW-1:0] rrd_cnt, wtr_cnt, lock_cnt;
    logic [RW-1:0] lock_val;

    assign lock_val = acc_ref ? RW'(T_RFC - 1) : RW'(T_MRD - 1);

    ddr_guard_dcnt #(.W(RW)) u_rrd  (.clk(clk), .rst(rst), .ld(acc_act),
                                     .ld_val(RW'(T_RRD - 1)), .cnt(rrd_cnt));
    ddr_guard_dcnt #(.W(RW)) u_wtr  (.clk(clk), .rst(rst), .ld(acc_wr),
                                     .ld_val(RW'(WTR_GAP - 1)), .cnt(wtr_cnt));
    ddr_guard_dcnt #(.W(RW)) u_lock (.clk(clk), .rst(rst), .ld(acc_ref || acc_lmr),
                                     .ld_val(lock_val), .cnt(lock_cnt));

    assign rrd_ok  = rrd_cnt == '0;
    assign wtr_ok  = wtr_cnt == '0;
    assign lock_ok = lock_cnt == '0;

endmodule

// File: rtl/ddr_cmd_guard.sv
module ddr_cmd_guard
    import ddr_guard_pkg::*;
#(
    parameter int NBANK     = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 8,
    parameter int T_RAS_MAX = 14000,
    parameter int T_RC      = 11,
    parameter int T_RRD     = 2,
    parameter int T_WL      = 1,
    parameter int T_BURST   = 2,
    parameter int T_WR      = 3,
    parameter int T_WTR     = 1,
    parameter int T_RFC     = 14,
    parameter int T_MRD     = 2,
    localparam int BA_W     = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_vld,
    input  logic [2:0]       cmd_code,
    input  logic [BA_W-1:0]  cmd_bank,
    input  logic             cmd_ap,
    output logic             ok_act,
    output logic             ok_rd,
    output logic             ok_wr,
    output logic             ok_pre,
    output logic             ok_ref,
    output logic             ok_lmr,
    output logic [NBANK-1:0] row_expire,
    output logic             violation
);

    localparam int WR_REC    = T_WL + T_BURST + T_WR;
    localparam int WTR_GAP   = T_WL + T_BURST + T_WTR;
    localparam int RD_AP_DLY = T_BURST;
    localparam int WR_AP_DLY = WR_REC;

    cmd_e       code;
    bank_stat_t st [NBANK];
    bank_stat_t sel;
    permit_t    perm;
    logic       cmd_ok, accepted, all_idle;
    logic       rrd_ok, wtr_ok, lock_ok;

    assign code = cmd_e'(cmd_code);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_req_t req;
        always_comb begin
            req.act = accepted && code == CMD_ACT && cmd_bank == BA_W'(b);
            req.rd  = accepted && code == CMD_RD  && cmd_bank == BA_W'(b);
            req.wr  = accepted && code == CMD_WR  && cmd_bank == BA_W'(b);
            req.pre = accepted && code == CMD_PRE && cmd_bank == BA_W'(b);
            req.ap  = cmd_ap;
        end
        ddr_guard_bank #(
            .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
            .T_RAS_MAX(T_RAS_MAX), .RD_AP_DLY(RD_AP_DLY),
            .WR_AP_DLY(WR_AP_DLY), .WR_REC(WR_REC)
        ) u_bank (
            .clk(clk), .rst(rst), .req(req), .stat(st[b])
        );
        assign row_expire[b] = st[b].expire;
    end

    ddr_guard_rank #(
        .T_RRD(T_RRD), .WTR_GAP(WTR_GAP), .T_RFC(T_RFC), .T_MRD(T_MRD)
    ) u_rank (
        .clk(clk), .rst(rst),
        .acc_act(accepted && code == CMD_ACT),
        .acc_wr (accepted && code == CMD_WR),
        .acc_ref(accepted && code == CMD_REF),
        .acc_lmr(accepted && code == CMD_LMR),
        .rrd_ok(rrd_ok), .wtr_ok(wtr_ok), .lock_ok(lock_ok)
    );

    always_comb begin
        all_idle = 1'b1;
        for (int b = 0; b < NBANK; b++) begin
            all_idle = all_idle && st[b].act_ok;
        end
    end

    assign sel = st[cmd_bank];

    always_comb begin
        perm.act  = lock_ok && rrd_ok && sel.act_ok;
        perm.rd   = lock_ok && wtr_ok && sel.col_ok && (!cmd_ap || sel.rd_ap_ok);
        perm.wr   = lock_ok && sel.col_ok && (!cmd_ap || sel.wr_ap_ok);
        perm.pre  = lock_ok && sel.pre_ok;
        perm.rfsh = lock_ok && all_idle;
        perm.lmr  = lock_ok && all_idle;
    end

    always_comb begin
        unique case (code)
            CMD_ACT: cmd_ok = perm.act;
            CMD_RD:  cmd_ok = perm.rd;
            CMD_WR:  cmd_ok = perm.wr;
            CMD_PRE: cmd_ok = perm.pre;
            CMD_REF: cmd_ok = perm.rfsh;
            CMD_LMR: cmd_ok = perm.lmr;
            default: cmd_ok = 1'b1;
        endcase
    end

    assign accepted = cmd_vld && cmd_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            violation <= 1'b0;
        end else if (cmd_vld && !cmd_ok) begin
            violation <= 1'b1;
        end
    end

    assign ok_act = perm.act;
    assign ok_rd  = perm.rd;
    assign ok_wr  = perm.wr;
    assign ok_pre = perm.pre;
    assign ok_ref = perm.rfsh;
    assign ok_lmr = perm.lmr;

endmodule

// File: rtl/ddr_cmd_guard_chk.sv
module ddr_cmd_guard_chk #(
    parameter int NBANK   = 4,
    parameter int T_RRD   = 2,
    parameter int WTR_GAP = 4,
    parameter int T_RFC   = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_vld,
    input logic [2:0]       cmd_code,
    input logic             ok_act,
    input logic             ok_rd,
    input logic             ok_wr,
    input logic             ok_pre,
    input logic             ok_ref,
    input logic             ok_lmr,
    input logic [NBANK-1:0] row_expire,
    input logic             violation
);

    logic blocked;
    always_comb begin
        case (cmd_code)
            3'd1:    blocked = !ok_act;
            3'd2:    blocked = !ok_rd;
            3'd3:    blocked = !ok_wr;
            3'd4:    blocked = !ok_pre;
            3'd5:    blocked = !ok_ref;
            3'd6:    blocked = !ok_lmr;
            default: blocked = 1'b0;
        endcase
    end

    p_sticky_viol_r10: assert property (@(posedge clk) disable iff (rst)
        violation |=> violation);

    p_viol_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(violation) |-> $past(cmd_vld && blocked));

    p_open_closed_r2: assert property (@(posedge clk) disable iff (rst)
        ok_act |-> !(ok_rd || ok_wr));

    p_rrd_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (T_RRD > 1 && cmd_vld && cmd_code == 3'd1 && ok_act) |=> !ok_act);

    p_wtr_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (WTR_GAP > 1 && cmd_vld && cmd_code == 3'd3 && ok_wr) |=> !ok_rd);

    p_ref_lock_r8: assert property (@(posedge clk) disable iff (rst)
        (T_RFC > 1 && cmd_vld && cmd_code == 3'd5 && ok_ref)
        |=> !(ok_act || ok_rd || ok_wr || ok_pre || ok_ref || ok_lmr));

    p_expire_single_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_expire));

    for (genvar b = 0; b < NBANK; b++) begin : g_exp
        p_expire_pulse_r9: assert property (@(posedge clk) disable iff (rst)
            row_expire[b] |=> !row_expire[b]);
    end

endmodule

bind ddr_cmd_guard ddr_cmd_guard_chk #(
    .NBANK(NBANK), .T_RRD(T_RRD), .WTR_GAP(T_WL + T_BURST + T_WTR), .T_RFC(T_RFC)
) u_chk (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
    .ok_act(ok_act), .ok_rd(ok_rd), .ok_wr(ok_wr), .ok_pre(ok_pre),
    .ok_ref(ok_ref), .ok_lmr(ok_lmr), .row_expire(row_expire),
    .violation(violation)
);

// File: tb/ddr_cmd_guard_test.sv
module ddr_cmd_guard_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_vld = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic       cmd_ap = 1'b0;
    logic       ok_act, ok_rd, ok_wr, ok_pre, ok_ref, ok_lmr;
    logic [3:0] row_expire;
    logic       violation;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ddr_cmd_guard uut (
        .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
        .ok_act(ok_act), .ok_rd(ok_rd), .ok_wr(ok_wr), .ok_pre(ok_pre),
        .ok_ref(ok_ref), .ok_lmr(ok_lmr), .row_expire(row_expire),
        .violation(violation)
    );

    // gap[16:13] vld[12] code[11:9] bank[8:7] ap[6] mask{lmr,ref,pre,wr,rd,act}[5:0]
    localparam int NV = 19;
    localparam logic [16:0] VEC [NV] = '{
        {4'd0,  1'b1, 3'd1, 2'd0, 1'b0, 6'b111001},
        {4'd0,  1'b0, 3'd1, 2'd1, 1'b0, 6'b001000},
        {4'd0,  1'b1, 3'd1, 2'd1, 1'b0, 6'b001001},
        {4'd0,  1'b1, 3'd2, 2'd0, 1'b0, 6'b000110},
        {4'd0,  1'b0, 3'd3, 2'd1, 1'b0, 6'b000000},
        {4'd0,  1'b1, 3'd3, 2'd1, 1'b0, 6'b000110},
        {4'd0,  1'b0, 3'd2, 2'd0, 1'b0, 6'b000100},
        {4'd0,  1'b0, 3'd2, 2'd0, 1'b1, 6'b000100},
        {4'd0,  1'b0, 3'd4, 2'd1, 1'b0, 6'b000100},
        {4'd0,  1'b1, 3'd2, 2'd0, 1'b1, 6'b001110},
        {4'd0,  1'b0, 3'd1, 2'd0, 1'b0, 6'b001000},
        {4'd0,  1'b1, 3'd4, 2'd1, 1'b0, 6'b001110},
        {4'd0,  1'b0, 3'd1, 2'd0, 1'b0, 6'b001000},
        {4'd0,  1'b0, 3'd1, 2'd0, 1'b0, 6'b001000},
        {4'd0,  1'b1, 3'd5, 2'd0, 1'b0, 6'b111001},
        {4'd0,  1'b0, 3'd1, 2'd2, 1'b0, 6'b000000},
        {4'd11, 1'b0, 3'd1, 2'd2, 1'b0, 6'b000000},
        {4'd0,  1'b1, 3'd1, 2'd2, 1'b0, 6'b111001},
        {4'd0,  1'b0, 3'd6, 2'd2, 1'b0, 6'b000000}
    };

    function automatic string row_req(input int i);
        case (i)
            0:            return "R1";
            1, 2:         return "R5";
            3, 4, 5, 18:  return "R2";
            6, 7, 8:      return "R6";
            11:           return "R3";
            14, 15, 16, 17: return "R8";
            default:      return "R7";
        endcase
    endfunction

    function automatic logic [5:0] pmask();
        return {ok_lmr, ok_ref, ok_pre, ok_wr, ok_rd, ok_act};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        cmd_vld = 1'b0;
    endtask

    task automatic look(input logic [2:0] c, input logic [1:0] b, input logic ap);
        @(negedge clk);
        cmd_vld = 1'b0; cmd_code = c; cmd_bank = b; cmd_ap = ap;
        #1;
    endtask

    task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic ap);
        @(negedge clk);
        cmd_vld = 1'b1; cmd_code = c; cmd_bank = b; cmd_ap = ap;
        tick();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmd_vld = 1'b0; cmd_code = 3'd0; cmd_bank = 2'd0; cmd_ap = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        look(3'd0, 2'd0, 1'b0);
        check("R1 permits", 32'(pmask()), 32'h39);
        check("R1 violation", 32'(violation), 32'd0);
        check("R1 row_expire", 32'(row_expire), 32'd0);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            logic [16:0] v;
            v = VEC[i];
            repeat (int'(v[16:13])) tick();
            @(negedge clk);
            cmd_vld = v[12]; cmd_code = v[11:9]; cmd_bank = v[8:7]; cmd_ap = v[6];
            #1;
            check(row_req(i), 32'(pmask()), 32'(v[5:0]));
            tick();
        end
        check("R10 no violation in legal walk", 32'(violation), 32'd0);

        // R4: ACTIVE->PRECHARGE and ACTIVE->ACTIVE same bank
        do_reset();
        issue(3'd1, 2'd3, 1'b0);
        repeat (6) tick();
        look(3'd4, 2'd3, 1'b0);
        check("R4 pre one early", 32'(ok_pre), 32'd0);
        tick();
        look(3'd4, 2'd3, 1'b0);
        check("R4 pre on time", 32'(ok_pre), 32'd1);
        issue(3'd4, 2'd3, 1'b0);
        tick();
        look(3'd1, 2'd3, 1'b0);
        check("R3 act one early", 32'(ok_act), 32'd0);
        tick();
        look(3'd1, 2'd3, 1'b0);
        check("R4 act after row cycle", 32'(ok_act), 32'd1);

        // R6: write recovery and write-to-read gap
        do_reset();
        issue(3'd1, 2'd0, 1'b0);
        tick(); tick();
        issue(3'd3, 2'd0, 1'b0);
        tick(); tick();
        look(3'd2, 2'd1, 1'b0);
        check("R6 read one early", 32'(ok_rd), 32'd0);
        tick();
        look(3'd2, 2'd0, 1'b0);
        check("R6 read on time", 32'(ok_rd), 32'd1);
        tick();
        look(3'd4, 2'd0, 1'b0);
        check("R6 pre one early", 32'(ok_pre), 32'd0);
        tick();
        look(3'd4, 2'd0, 1'b0);
        check("R6 pre on time", 32'(ok_pre), 32'd1);

        // R7: auto-precharge read threshold, write auto-precharge closure
        do_reset();
        issue(3'd1, 2'd1, 1'b0);
        repeat (4) tick();
        look(3'd2, 2'd1, 1'b1);
        check("R7 rd ap early", 32'(ok_rd), 32'd0);
        look(3'd2, 2'd1, 1'b0);
        check("R7 rd plain allowed", 32'(ok_rd), 32'd1);
        tick();
        look(3'd2, 2'd1, 1'b1);
        check("R7 rd ap on time", 32'(ok_rd), 32'd1);
        issue(3'd3, 2'd1, 1'b1);
        look(3'd2, 2'd1, 1'b0);
        check("R7 bank closed after wr ap", 32'(ok_rd), 32'd0);
        repeat (7) tick();
        look(3'd1, 2'd1, 1'b0);
        check("R7 act one early", 32'(ok_act), 32'd0);
        tick();
        look(3'd1, 2'd1, 1'b0);
        check("R7 act on time", 32'(ok_act), 32'd1);

        // R8: LOAD MODE lockout
        do_reset();
        issue(3'd6, 2'd0, 1'b0);
        look(3'd1, 2'd0, 1'b0);
        check("R8 lmr lock", 32'(pmask()), 32'h00);
        tick();
        look(3'd1, 2'd0, 1'b0);
        check("R8 lmr lock over", 32'(pmask()), 32'h39);

        // R10, R11: refused ACTIVE, sticky flag, reserved code
        do_reset();
        issue(3'd7, 2'd0, 1'b0);
        issue(3'd0, 2'd0, 1'b0);
        check("R10 nop and reserved", 32'(violation), 32'd0);
        issue(3'd1, 2'd0, 1'b0);
        issue(3'd1, 2'd1, 1'b0);
        check("R10 violation set", 32'(violation), 32'd1);
        look(3'd2, 2'd1, 1'b0);
        check("R11 refused act left bank closed", 32'(ok_rd), 32'd0);
        check("R11 refused act no rrd restart", 32'(ok_act), 32'd1);
        repeat (3) tick();
        check("R10 violation sticky", 32'(violation), 32'd1);
        do_reset();
        check("R10 cleared by reset", 32'(violation), 32'd0);

        // R12: precharge of closed bank
        issue(3'd4, 2'd2, 1'b0);
        look(3'd1, 2'd2, 1'b0);
        check("R12 closed pre no delay", 32'(ok_act), 32'd1);
        check("R12 closed pre no violation", 32'(violation), 32'd0);

        // R9: row timeout pulse
        do_reset();
        issue(3'd1, 2'd2, 1'b0);
        repeat (13997) tick();
        check("R9 not yet", 32'(row_expire), 32'd0);
        tick();
        check("R9 pulse", 32'(row_expire), 32'h4);
        tick();
        check("R9 single cycle", 32'(row_expire), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule